// File: doc/BRIEF.md
# Selectable Latched Configuration-Output Multiplexer

This block produces six configuration outputs for a board: five multiplexed lines and one latched line. Each multiplexed line carries either one of five external input pins or one bit of a six-bit non-volatile configuration word. A select pin chooses the source by default. A two-bit control register, written over the serial bus, can take that choice away from the pin. The latched line always comes from the top bit of the stored word. It either follows that bit or holds a value captured at a defined moment. An active-low override pin pulls the multiplexed lines low while they carry stored data. While the word is being reprogrammed, the outputs keep their previous values.

All outputs are active-high pull-low enables for open-drain pads: a 1 means the pad is driven to 0. The serial bus engine and the storage array sit outside the block. The bus engine delivers a write strobe with a command byte and a data byte, and a slave-acknowledge pulse. The storage side delivers the six-bit word and a programming-busy flag. The select pin passes through a synchronizer into the clock domain.

A five-state controller sets the source and the latch behaviour:
- `S_PIN_WORD`: pin mode, select low; stored source, latch transparent.
- `S_PIN_EXT`: pin mode, select high; external source, latch holding.
- `S_REG_WAIT`: register mode just entered; waiting for the acknowledge, latch holding.
- `S_REG_WORD`: register mode, stored source, latch transparent.
- `S_REG_EXT`: register mode, external source, latch holding.

Its transitions are:
- `S_PIN_WORD` and `S_PIN_EXT` follow the synchronized select.
- A qualifying write that sets control bit 1 moves a pin state to `S_REG_WAIT`.
- An acknowledge in `S_REG_WAIT` moves to `S_REG_WORD` or `S_REG_EXT` according to bit 0.
- Writes in register mode move between `S_REG_WORD` and `S_REG_EXT`.
- A write that clears bit 1 returns to the pin state chosen by select.

Top module: `cfgmux_top`

## Requirements
- R1: After reset the control register reads 0x00, and the outputs are controlled by the select and override pins (pin mode).
- R2: In pin mode with select low, `mux_pull[i]` is the inverse of stored bit i (i = 0..4). `nmo_pull` is the inverse of stored bit 5 and follows changes to it (transparent).
- R3: In pin mode with select high, `mux_pull` is the inverse of `ext_in`. A select change reaches the outputs within four clock cycles.
- R4: In pin mode, the latched value is the stored bit 5 captured at the rising edge of select. It holds while select stays high, whatever the stored word does.
- R5: When control bit 1 is set, the select pin has no effect on the outputs. Bit 0 = 1 selects the stored word and bit 0 = 0 selects `ext_in`.
- R6: In register mode, the latched value is stored bit 5 captured at the slave acknowledge that follows the write setting bit 1 from 0 to 1. Before that acknowledge, the previous latched value holds. Afterwards it follows bit 5 when bit 0 = 1 and holds when bit 0 = 0.
- R7: With `force_low_n` low, all `mux_pull` bits are 1 while the stored word is the source. `force_low_n` has no effect on an external source or on `nmo_pull`.
- R8: While `prog_busy` is high, the outputs keep the values of the stored word seen before busy rose. They take the new word within two cycles of busy falling.
- R9: Only a write with command byte 0x0B changes the control register, and only data bits [1:0] are stored. `ctl_rdata` returns them in bits [1:0], with bits [7:2] zero.
- R10: Each output is a pull-low enable: 1 drives the pad to logic 0, and 0 releases it to logic 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pin | input | 1 | Asynchronous source-select pin (0 = stored word) |
| force_low_n | input | 1 | Active-low force-low override |
| ext_in | input | 5 | External inputs for the multiplexed lines |
| stored_word | input | 6 | Non-volatile word; bits [4:0] for the mux lines, bit 5 for the latched line |
| prog_busy | input | 1 | High while the stored word is being reprogrammed |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_cmd | input | 8 | Command byte accompanying the write |
| ctl_wdata | input | 8 | Data byte accompanying the write |
| slv_ack | input | 1 | Slave-acknowledge pulse from the bus engine |
| ctl_rdata | output | 8 | Control register readback |
| mux_pull | output | 5 | Pull-low enables of the multiplexed lines |
| nmo_pull | output | 1 | Pull-low enable of the latched line |

## Verification
The bench builds the block with its defaults: five multiplexed lines, a two-stage select synchronizer and command code 0x0B. With these values, every line of the 5-bit external bus and of the 6-bit word can be hit by random patterns. The synchronizer delay is short enough for the bench to check that a select change reaches the outputs within four cycles. Directed sequences put the controller through every state. These include the wait for an acknowledge with the stored bit changed in between, a busy window with a word change during it, and writes with a wrong command byte or with upper data bits set.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;
    typedef enum logic [2:0] {
        S_PIN_WORD,
        S_PIN_EXT,
        S_REG_WAIT,
        S_REG_WORD,
        S_REG_EXT
    } mode_e;

    localparam int CTL_BITS = 2;
endpackage

// File: rtl/cfgmux_sync.sv
module cfgmux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cfgmux_ctl.sv
module cfgmux_ctl
    import cfgmux_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  CTL_CMD = 8'h0B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_s,
    input  logic                ctl_wr,
    input  logic [7:0]          ctl_cmd,
    input  logic [DATA_W-1:0]   ctl_wdata,
    input  logic                slv_ack,
    output logic [CTL_BITS-1:0] ctl_q,
    output logic                transparent,
    output logic                src_word,
    output logic                cap
);
    mode_e               state_q, state_d;
    logic [CTL_BITS-1:0] ctl_d;
    logic                wr_hit;
    logic                unused_hi;

    assign unused_hi = ^ctl_wdata[DATA_W-1:CTL_BITS];

    // state and control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_PIN_WORD;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    // next state
    always_comb begin
        wr_hit  = ctl_wr && (ctl_cmd == CTL_CMD);
        ctl_d   = wr_hit ? ctl_wdata[CTL_BITS-1:0] : ctl_q;
        state_d = state_q;
        unique case (state_q)
            S_PIN_WORD, S_PIN_EXT: begin
                if (wr_hit && ctl_d[1])
                    state_d = S_REG_WAIT;
                else
                    state_d = sel_s ? S_PIN_EXT : S_PIN_WORD;
            end
            S_REG_WAIT: begin
                if (wr_hit && !ctl_d[1])
                    state_d = sel_s ? S_PIN_EXT : S_PIN_WORD;
                else if (!wr_hit && slv_ack)
                    state_d = ctl_q[0] ? S_REG_WORD : S_REG_EXT;
            end
            S_REG_WORD, S_REG_EXT: begin
                if (wr_hit && !ctl_d[1])
                    state_d = sel_s ? S_PIN_EXT : S_PIN_WORD;
                else
                    state_d = ctl_d[0] ? S_REG_WORD : S_REG_EXT;
            end
            default: state_d = S_PIN_WORD;
        endcase
    end

    // decoded controls
    always_comb begin
        transparent = 1'b0;
        src_word    = 1'b0;
        cap         = 1'b0;
        unique case (state_q)
            S_PIN_WORD: begin
                transparent = 1'b1;
                src_word    = 1'b1;
            end
            S_PIN_EXT: ;
            S_REG_WAIT: begin
                src_word = ctl_q[0];
                cap      = slv_ack && !wr_hit;
            end
            S_REG_WORD: begin
                transparent = 1'b1;
                src_word    = 1'b1;
            end
            S_REG_EXT: ;
            default: ;
        endcase
    end

    AST_PIN_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[1] |-> (state_q == S_PIN_WORD || state_q == S_PIN_EXT)); // R1
    AST_PIN_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[1] && !wr_hit && $rose(sel_s)) |=> (state_q == S_PIN_EXT)); // R4
    AST_REG_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[1] && !wr_hit && state_q != S_REG_WAIT) |=> $stable(state_q)); // R5
    AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_cmd != CTL_CMD) |=> $stable(ctl_q)); // R9
endmodule

// File: rtl/cfgmux_hold.sv
module cfgmux_hold #(
    parameter int N_MUX = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_busy,
    input  logic [N_MUX:0] stored_word,
    input  logic           transparent,
    input  logic           cap,
    output logic [N_MUX:0] word_q,
    output logic           nmo_val
);
    logic nmo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            nmo_q  <= 1'b0;
        end else begin
            if (!prog_busy)
                word_q <= stored_word;
            if (transparent || cap)
                nmo_q <= word_q[N_MUX];
        end
    end

    assign nmo_val = transparent ? word_q[N_MUX] : nmo_q;

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> $stable(word_q)); // R8
    AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (nmo_q == $past(word_q[N_MUX]))); // R6
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!transparent && !cap) |=> $stable(nmo_q)); // R4
endmodule

// File: rtl/cfgmux_top.sv
module cfgmux_top
    import cfgmux_pkg::*;
#(
    parameter int         N_MUX       = 5,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CTL_CMD     = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_pin,
    input  logic              force_low_n,
    input  logic [N_MUX-1:0]  ext_in,
    input  logic [N_MUX:0]    stored_word,
    input  logic              prog_busy,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_cmd,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              slv_ack,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic [N_MUX-1:0]  mux_pull,
    output logic              nmo_pull
);
    localparam int PAD_W = DATA_W - CTL_BITS;

    logic                sel_s;
    logic [CTL_BITS-1:0] ctl_q;
    logic                transparent, src_word, cap;
    logic [N_MUX:0]      word_q;
    logic                nmo_val;

    cfgmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sel_pin),
        .q_sync  (sel_s)
    );

    cfgmux_ctl #(.DATA_W(DATA_W), .CTL_CMD(CTL_CMD)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_s       (sel_s),
        .ctl_wr      (ctl_wr),
        .ctl_cmd     (ctl_cmd),
        .ctl_wdata   (ctl_wdata),
        .slv_ack     (slv_ack),
        .ctl_q       (ctl_q),
        .transparent (transparent),
        .src_word    (src_word),
        .cap         (cap)
    );

    cfgmux_hold #(.N_MUX(N_MUX)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_busy   (prog_busy),
        .stored_word (stored_word),
        .transparent (transparent),
        .cap         (cap),
        .word_q      (word_q),
        .nmo_val     (nmo_val)
    );

    assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};

    generate
        for (genvar i = 0; i < N_MUX; i++) begin : g_line
            logic line_val;
            always_comb begin
                if (src_word)
                    line_val = force_low_n & word_q[i];
                else
                    line_val = ext_in[i];
            end
            assign mux_pull[i] = ~line_val;
        end
    endgenerate

    assign nmo_pull = ~nmo_val;

    AST_FORCE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_word && !force_low_n) |-> (&mux_pull)); // R7
    AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !src_word |-> (mux_pull == ~ext_in)); // R3
endmodule

// File: tb/sim_cfgmux_top.sv
`timescale 1ns/1ps
module sim_cfgmux_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_pin, force_low_n, prog_busy, ctl_wr, slv_ack;
    logic [4:0] ext_in;
    logic [5:0] stored_word;
    logic [7:0] ctl_cmd, ctl_wdata, ctl_rdata;
    logic [4:0] mux_pull;
    logic       nmo_pull;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    cfgmux_top u0 (
        .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .force_low_n(force_low_n),
        .ext_in(ext_in), .stored_word(stored_word), .prog_busy(prog_busy),
        .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd), .ctl_wdata(ctl_wdata),
        .slv_ack(slv_ack), .ctl_rdata(ctl_rdata), .mux_pull(mux_pull),
        .nmo_pull(nmo_pull)
    );

    function automatic logic [4:0] exp_mux(input bit from_word, input logic [5:0] w,
                                           input logic [4:0] e, input bit f_n);
        logic [4:0] v;
        v = from_word ? (f_n ? w[4:0] : 5'd0) : e;
        return ~v;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] cmd, input logic [7:0] data);
        ctl_wr = 1'b1; ctl_cmd = cmd; ctl_wdata = data;
        step(1);
        ctl_wr = 1'b0;
        step(1);
    endtask

    task automatic ack();
        slv_ack = 1'b1;
        step(1);
        slv_ack = 1'b0;
        step(1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sel_pin = 1'b0; force_low_n = 1'b1; prog_busy = 1'b0;
        ctl_wr = 1'b0; slv_ack = 1'b0; ctl_cmd = 8'h00; ctl_wdata = 8'h00;
        ext_in = 5'h00; stored_word = 6'h2A;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        chk("R1 ctl reset", ctl_rdata, 8'h00);
        chk("R2 mux word", {3'b0, mux_pull}, {3'b0, exp_mux(1, 6'h2A, 5'h00, 1)});
        chk("R10 nmo bit5=1 releases", {7'b0, nmo_pull}, 8'h00);
        stored_word = 6'h15; step(2);
        chk("R2 transparent nmo", {7'b0, nmo_pull}, 8'h01);
        chk("R10 mux pull", {3'b0, mux_pull}, {3'b0, ~5'h15});

        // R4 capture at select rising edge
        stored_word = 6'h3F; step(2);
        sel_pin = 1'b1; step(4);
        stored_word = 6'h00; step(2);
        chk("R4 nmo held after rise", {7'b0, nmo_pull}, 8'h00);
        // R3 R7 external source, random
        for (int i = 0; i < 20; i++) begin
            ext_in      = 5'($urandom);
            stored_word = 6'($urandom) & 6'h1F;
            force_low_n = 1'($urandom);
            step(2);
            chk("R3 ext source", {3'b0, mux_pull}, {3'b0, exp_mux(0, stored_word, ext_in, force_low_n)});
            chk("R4 nmo still held", {7'b0, nmo_pull}, 8'h00);
        end
        force_low_n = 1'b1;

        // R2 R7 stored source, random
        sel_pin = 1'b0; step(4);
        for (int i = 0; i < 20; i++) begin
            ext_in      = 5'($urandom);
            stored_word = 6'($urandom);
            force_low_n = 1'($urandom);
            step(2);
            chk("R7 word source force", {3'b0, mux_pull}, {3'b0, exp_mux(1, stored_word, ext_in, force_low_n)});
            chk("R7 nmo unaffected", {7'b0, nmo_pull}, {7'b0, ~stored_word[5]});
        end
        force_low_n = 1'b1;

        // R8 busy freeze
        stored_word = 6'h0C; step(2);
        prog_busy = 1'b1; stored_word = 6'h33; step(3);
        chk("R8 mux frozen", {3'b0, mux_pull}, {3'b0, ~5'h0C});
        chk("R8 nmo frozen", {7'b0, nmo_pull}, 8'h01);
        prog_busy = 1'b0; step(2);
        chk("R8 mux updated", {3'b0, mux_pull}, {3'b0, ~5'h13});
        chk("R8 nmo updated", {7'b0, nmo_pull}, 8'h00);

        // R9 command qualification
        wr_ctl(8'h0A, 8'h02);
        chk("R9 wrong cmd ignored", ctl_rdata, 8'h00);
        chk("R9 still pin mode", {3'b0, mux_pull}, {3'b0, ~5'h13});
        wr_ctl(8'h0B, 8'hFD);
        chk("R9 low bits only", ctl_rdata, 8'h01);

        // R6 acknowledge-timed capture
        stored_word = 6'h20; ext_in = 5'h0A; step(2);
        chk("R2 nmo before reg mode", {7'b0, nmo_pull}, 8'h00);
        wr_ctl(8'h0B, 8'h02);
        stored_word = 6'h00; step(2);
        chk("R6 held before ack", {7'b0, nmo_pull}, 8'h00);
        chk("R5 ext while waiting", {3'b0, mux_pull}, {3'b0, ~5'h0A});
        ack();
        chk("R6 captured at ack", {7'b0, nmo_pull}, 8'h01);
        stored_word = 6'h20; step(2);
        chk("R6 holds with bit0=0", {7'b0, nmo_pull}, 8'h01);
        sel_pin = 1'b1; step(4); sel_pin = 1'b0; step(4);
        chk("R5 pin ignored ext", {3'b0, mux_pull}, {3'b0, ~5'h0A});

        wr_ctl(8'h0B, 8'h03);
        chk("R9 readback 3", ctl_rdata, 8'h03);
        chk("R6 follows with bit0=1", {7'b0, nmo_pull}, 8'h00);
        sel_pin = 1'b1; step(4);
        chk("R5 pin ignored word", {3'b0, mux_pull}, {3'b0, exp_mux(1, 6'h20, 5'h0A, 1)});
        for (int i = 0; i < 20; i++) begin
            sel_pin     = 1'($urandom);
            ext_in      = 5'($urandom);
            stored_word = 6'($urandom);
            force_low_n = 1'($urandom);
            step(4);
            chk("R5 reg word source", {3'b0, mux_pull}, {3'b0, exp_mux(1, stored_word, ext_in, force_low_n)});
            chk("R6 reg transparent", {7'b0, nmo_pull}, {7'b0, ~stored_word[5]});
        end
        force_low_n = 1'b1;

        // R1 back to pin mode
        sel_pin = 1'b1; ext_in = 5'h11; step(4);
        wr_ctl(8'h0B, 8'h00);
        step(1);
        chk("R1 pin mode again", {3'b0, mux_pull}, {3'b0, ~5'h11});
        chk("R9 cleared", ctl_rdata, 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule